// File: doc/BRIEF.md
# USB Device Control and Interrupt Register Block

This block holds the software-visible control state of a USB device controller. A small synchronous register bus reaches three 8-bit registers: a device control register (speed choice, remote wake-up request, detach), a general interrupt flag register, and an interrupt enable register with the same bit layout as the flag register. The USB line engine delivers one-cycle event pulses for start of frame, suspend, end of bus reset, end of host resume and non-idle line activity. Each pulse sets its flag.

The block drives the pull-up enables for D+ and D-. Full speed uses D+, low speed uses D-. Both are off while the device is detached or the controller is in host mode. When software asks for remote wake-up while the suspend flag is set, the block drives a resume request for a fixed number of cycles, given by a parameter. It then clears the request bit by itself. One interrupt line is high while any enabled flag is set.

Register offsets are `bus_addr` 0 = control, 1 = flags, 2 = enables, 3 = unused (reads 0). Writes take effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The reset input is asynchronous and active low. Its release is synchronized over two clock edges.

Top module: `usb_dev_ctrl_regs`

## Requirements
- R1: The control register reads speed at bit 2, wake-up request at bit 1 and detach at bit 0. Bits 7..3 always read 0. After reset it reads 0x01 (detached).
- R2: In device mode (`host_mode`=0) with detach=0, speed=0 enables only the D+ pull-up and speed=1 enables only the D- pull-up. With detach=1 neither pull-up is enabled.
- R3: With `host_mode`=1 both pull-up enables are 0, whatever the speed and detach bits hold.
- R4: Writing 1 to the wake-up request bit starts resume only while the suspend flag (flag bit 0) is 1. Otherwise the bit stays 0 and `resume_drive` stays 0.
- R5: Once started, `resume_drive` is high for exactly RESUME_CYCLES cycles and the wake-up bit reads 1 during that time. The bit then clears by hardware. Writes of 0 to it during the drive have no effect.
- R6: The flag register holds upstream resume at bit 6, end of resume at bit 5, wake-up at bit 4, end of reset at bit 3, start of frame at bit 2 and suspend at bit 0. Bits 7 and 1 read 0, and all bits are 0 after reset.
- R7: An event pulse in one cycle sets its flag, readable from the next cycle on.
- R8: Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged, so software can never set a flag.
- R9: If an event pulse and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: The upstream resume flag (bit 6) is set in the same edge at which `resume_drive` rises.
- R11: Non-idle activity sets the wake-up flag (bit 4) only while the block is not driving its own resume.
- R12: `irq` is 1 exactly when some flag bit and the enable bit at the same position are both 1. The enable register's bits 7 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 2 | Register select (0 control, 1 flags, 2 enables) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| host_mode | input | 1 | Controller is in host mode |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_suspend | input | 1 | Suspend detected pulse |
| ev_end_reset | input | 1 | End of bus reset pulse |
| ev_end_resume | input | 1 | End of host resume pulse |
| ev_nonidle | input | 1 | Filtered non-idle line activity pulse |
| dp_pullup_en | output | 1 | D+ pull-up enable |
| dm_pullup_en | output | 1 | D- pull-up enable |
| resume_drive | output | 1 | Request to drive upstream resume |
| irq | output | 1 | Interrupt request |

## Verification
A hardware event pulse and a software write that clears the flag register can occur in the same clock cycle. The bench provokes this by holding the start-of-frame pulse high during a flag write of all zeros, which also clears the other pending flags. It passes only if the start-of-frame flag survives while the cleared bits are gone. A second overlap is non-idle activity arriving while the block is driving its own resume: the bench pulses it during the drive and expects no wake-up flag, then pulses it again afterwards and expects the flag.

// File: rtl/usbdc_pkg.sv
package usbdc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_FLAG = 2'd1,
    REG_IEN  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int CTL_SPEED  = 2;
  localparam int CTL_WAKE   = 1;
  localparam int CTL_DETACH = 0;

  // flag / enable register bit positions
  localparam int FLG_UPRSM = 6;
  localparam int FLG_EORSM = 5;
  localparam int FLG_WAKE  = 4;
  localparam int FLG_EORST = 3;
  localparam int FLG_SOF   = 2;
  localparam int FLG_SUSP  = 0;

  localparam logic [DATA_W-1:0] FLAG_MASK = 8'h7D;
endpackage

// File: rtl/usbdc_ctrl.sv
module usbdc_ctrl
  import usbdc_pkg::*;
#(
  parameter int RESUME_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              host_mode,
  input  logic              susp_flag,
  output logic [DATA_W-1:0] ctrl_rdata,
  output logic              dp_pu,
  output logic              dm_pu,
  output logic              resume_drive,
  output logic              resume_start
);
  localparam int CNT_W = (RESUME_CYCLES > 1) ? $clog2(RESUME_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESUME_CYCLES - 1);

  logic             speed_q, speed_d;
  logic             detach_q, detach_d;
  logic             wake_q, wake_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_last;

  always_comb begin
    speed_d      = wr_en ? wdata[CTL_SPEED]  : speed_q;
    detach_d     = wr_en ? wdata[CTL_DETACH] : detach_q;
    resume_start = wr_en && wdata[CTL_WAKE] && susp_flag && !wake_q;
    cnt_last     = wake_q && (cnt_q == CNT_LAST);
    if (resume_start)  wake_d = 1'b1;
    else if (cnt_last) wake_d = 1'b0;
    else               wake_d = wake_q;
    cnt_d = (wake_q && !cnt_last) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speed_q  <= 1'b0;
      detach_q <= 1'b1;
      wake_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      speed_q  <= speed_d;
      detach_q <= detach_d;
      wake_q   <= wake_d;
      cnt_q    <= cnt_d;
    end
  end

  always_comb begin
    ctrl_rdata             = '0;
    ctrl_rdata[CTL_SPEED]  = speed_q;
    ctrl_rdata[CTL_WAKE]   = wake_q;
    ctrl_rdata[CTL_DETACH] = detach_q;
  end

  assign dp_pu        = !host_mode && !detach_q && !speed_q;
  assign dm_pu        = !host_mode && !detach_q &&  speed_q;
  assign resume_drive = wake_q;

  // R2: never both pull-ups at once
  a_r2_single_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_pu && dm_pu));
  // R3: host mode keeps both pull-ups off
  a_r3_host_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode |-> (!dp_pu && !dm_pu));
  // R4: resume only begins after a cycle with the suspend flag set
  a_r4_needs_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_drive) |-> $past(susp_flag));
  // R5: the duration counter stays inside its window
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  // R5: counter is idle while no resume is driven
  a_r5_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_drive |-> (cnt_q == '0));
endmodule

// File: rtl/usbdc_irq.sv
module usbdc_irq
  import usbdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_wr,
  input  logic              ien_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_sof,
  input  logic              ev_suspend,
  input  logic              ev_end_reset,
  input  logic              ev_end_resume,
  input  logic              ev_nonidle,
  input  logic              resume_start,
  input  logic              resume_active,
  output logic [DATA_W-1:0] flag_q,
  output logic [DATA_W-1:0] ien_q,
  output logic              irq
);
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] flag_d;
  logic [DATA_W-1:0] ien_d;

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_UPRSM] = resume_start;
    set_vec[FLG_EORSM] = ev_end_resume;
    set_vec[FLG_WAKE]  = ev_nonidle && !resume_active && !resume_start;
    set_vec[FLG_EORST] = ev_end_reset;
    set_vec[FLG_SOF]   = ev_sof;
    set_vec[FLG_SUSP]  = ev_suspend;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (FLAG_MASK[i]) begin : g_live
      always_comb begin
        flag_d[i] = (flag_wr ? (flag_q[i] & wdata[i]) : flag_q[i]) | set_vec[i];
        ien_d[i]  = ien_wr ? wdata[i] : ien_q[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flag_q[i] <= 1'b0;
          ien_q[i]  <= 1'b0;
        end else begin
          flag_q[i] <= flag_d[i];
          ien_q[i]  <= ien_d[i];
        end
      end
    end else begin : g_rsvd
      assign flag_d[i] = 1'b0;
      assign ien_d[i]  = 1'b0;
      assign flag_q[i] = 1'b0;
      assign ien_q[i]  = 1'b0;
    end
  end

  assign irq = |(flag_q & ien_q);

  // R8: a flag only rises where hardware raised a set request
  a_r8_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_vec)) == '0));
  // R9: every hardware set lands, even against a clearing write
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));
  // R10: upstream resume flag rises together with the drive
  a_r10_uprsm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_active) |-> flag_q[FLG_UPRSM]);
  // R11: wake-up flag never comes from the block's own resume
  a_r11_wake_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[FLG_WAKE]) |-> $past(ev_nonidle && !resume_active));
endmodule

// File: rtl/usb_dev_ctrl_regs.sv
module usb_dev_ctrl_regs
  import usbdc_pkg::*;
#(
  parameter int RESUME_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              host_mode,
  input  logic              ev_sof,
  input  logic              ev_suspend,
  input  logic              ev_end_reset,
  input  logic              ev_end_resume,
  input  logic              ev_nonidle,
  output logic              dp_pullup_en,
  output logic              dm_pullup_en,
  output logic              resume_drive,
  output logic              irq
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              wr_ctrl, wr_flag, wr_ien;
  logic [DATA_W-1:0] ctrl_rdata, flag_q, ien_q;
  logic              resume_start;
  reg_sel_e          sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign sel     = reg_sel_e'(bus_addr);
  assign wr_ctrl = bus_wr && (sel == REG_CTRL);
  assign wr_flag = bus_wr && (sel == REG_FLAG);
  assign wr_ien  = bus_wr && (sel == REG_IEN);

  usbdc_ctrl #(.RESUME_CYCLES(RESUME_CYCLES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_en        (wr_ctrl),
    .wdata        (bus_wdata),
    .host_mode    (host_mode),
    .susp_flag    (flag_q[FLG_SUSP]),
    .ctrl_rdata   (ctrl_rdata),
    .dp_pu        (dp_pullup_en),
    .dm_pu        (dm_pullup_en),
    .resume_drive (resume_drive),
    .resume_start (resume_start)
  );

  usbdc_irq u_irq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .flag_wr       (wr_flag),
    .ien_wr        (wr_ien),
    .wdata         (bus_wdata),
    .ev_sof        (ev_sof),
    .ev_suspend    (ev_suspend),
    .ev_end_reset  (ev_end_reset),
    .ev_end_resume (ev_end_resume),
    .ev_nonidle    (ev_nonidle),
    .resume_start  (resume_start),
    .resume_active (resume_drive),
    .flag_q        (flag_q),
    .ien_q         (ien_q),
    .irq           (irq)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL: bus_rdata = ctrl_rdata;
      REG_FLAG: bus_rdata = flag_q;
      REG_IEN:  bus_rdata = ien_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R12: interrupt line low whenever the enable register is empty
  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/test_usb_dev_ctrl_regs.sv
module test_usb_dev_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       host_mode;
  logic       ev_sof, ev_suspend, ev_end_reset, ev_end_resume, ev_nonidle;
  logic       dp_pullup_en, dm_pullup_en, resume_drive, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_dev_ctrl_regs #(.RESUME_CYCLES(RC)) i_usb_dev_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_mode(host_mode),
    .ev_sof(ev_sof), .ev_suspend(ev_suspend), .ev_end_reset(ev_end_reset),
    .ev_end_resume(ev_end_resume), .ev_nonidle(ev_nonidle),
    .dp_pullup_en(dp_pullup_en), .dm_pullup_en(dm_pullup_en),
    .resume_drive(resume_drive), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_sof = 1'b1;
      1: ev_suspend = 1'b1;
      2: ev_end_reset = 1'b1;
      3: ev_end_resume = 1'b1;
      default: ev_nonidle = 1'b1;
    endcase
    @(negedge clk);
    ev_sof = 0; ev_suspend = 0; ev_end_reset = 0; ev_end_resume = 0; ev_nonidle = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 reset control", d, 8'h01);
    rd(2'd1, d); chk("R6 reset flags", d, 8'h00);
    rd(2'd2, d); chk("R12 reset enables", d, 8'h00);
    chk("R2 reset pullups", {6'd0, dp_pullup_en, dm_pullup_en}, 8'h00);
    chk("R5 reset resume", {7'd0, resume_drive}, 8'h00);
    chk("R12 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ctrl_pullups();
    logic [7:0] d;
    wr(2'd0, 8'hF8);
    rd(2'd0, d); chk("R1 reserved bits read 0", d, 8'h00);
    chk("R2 full speed D+", {6'd0, dp_pullup_en, dm_pullup_en}, 8'h02);
    wr(2'd0, 8'h04);
    chk("R2 low speed D-", {6'd0, dp_pullup_en, dm_pullup_en}, 8'h01);
    wr(2'd0, 8'h05);
    chk("R2 detached low speed", {6'd0, dp_pullup_en, dm_pullup_en}, 8'h00);
    wr(2'd0, 8'h01);
    chk("R2 detached full speed", {6'd0, dp_pullup_en, dm_pullup_en}, 8'h00);
    @(negedge clk); host_mode = 1'b1;
    wr(2'd0, 8'h00);
    chk("R3 host full speed", {6'd0, dp_pullup_en, dm_pullup_en}, 8'h00);
    wr(2'd0, 8'h04);
    chk("R3 host low speed", {6'd0, dp_pullup_en, dm_pullup_en}, 8'h00);
    @(negedge clk); host_mode = 1'b0;
    #1; chk("R2 device again low speed", {6'd0, dp_pullup_en, dm_pullup_en}, 8'h01);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_wake_no_suspend();
    logic [7:0] d;
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R4 wake ignored without suspend", d, 8'h00);
    chk("R4 no resume drive", {7'd0, resume_drive}, 8'h00);
    rd(2'd1, d); chk("R4 no upstream resume flag", d, 8'h00);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    wr(2'd2, 8'hFF);
    rd(2'd2, d); chk("R12 enable reserved bits", d, 8'h7D);
    wr(2'd2, 8'h00);
    pulse(0); rd(2'd1, d); chk("R7 sof flag bit2", d, 8'h04);
    pulse(1); rd(2'd1, d); chk("R7 suspend flag bit0", d, 8'h05);
    pulse(2); rd(2'd1, d); chk("R7 end reset bit3", d, 8'h0D);
    pulse(3); rd(2'd1, d); chk("R7 end resume bit5", d, 8'h2D);
    pulse(4); rd(2'd1, d); chk("R7 wake bit4", d, 8'h3D);
    chk("R12 no irq with enables off", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R8 write 1 keeps flags", d, 8'h3D);
    wr(2'd1, 8'hFB);
    rd(2'd1, d); chk("R8 write 0 clears sof", d, 8'h39);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R8 clear all", d, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, d); chk("R6 R8 software cannot set", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(2'd2, 8'h04);
    chk("R12 enabled but no flag", {7'd0, irq}, 8'h00);
    pulse(2);
    chk("R12 other flag not enabled", {7'd0, irq}, 8'h00);
    pulse(0);
    chk("R12 sof flag and enable", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h00);
    chk("R12 enable removed", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R8 cleared before race", d, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    pulse(1); pulse(2);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h00; ev_sof = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ev_sof = 1'b0;
    rd(2'd1, d); chk("R9 set beats clear", d, 8'h04);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_resume();
    logic [7:0] d;
    int hi;
    pulse(1);
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R4 wake accepted while suspended", d, 8'h02);
    rd(2'd1, d); chk("R10 upstream resume flag", d, 8'h41);
    chk("R10 drive with flag", {7'd0, resume_drive}, 8'h01);
    hi = 1;
    // two cycles in: non-idle during own resume must not set wake flag
    @(negedge clk); ev_nonidle = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h00;
    if (resume_drive) hi++;
    @(negedge clk); ev_nonidle = 1'b0; bus_wr = 1'b0;
    if (resume_drive) hi++;
    rd(2'd0, d); chk("R5 write 0 to wake ignored", d, 8'h02);
    rd(2'd1, d); chk("R11 no wake flag from own resume", d, 8'h41);
    for (int k = 0; k < 4 * RC; k++) begin
      @(negedge clk);
      if (resume_drive) hi++;
    end
    chk("R5 drive length", 8'(hi), 8'(RC));
    rd(2'd0, d); chk("R5 wake bit cleared by hardware", d, 8'h00);
    pulse(4);
    rd(2'd1, d); chk("R11 wake flag after resume", d, 8'h51);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
    host_mode = 1'b0; ev_sof = 0; ev_suspend = 0; ev_end_reset = 0;
    ev_end_resume = 0; ev_nonidle = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl_pullups();
    t_wake_no_suspend();
    t_flags();
    t_irq();
    t_race();
    t_resume();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule